// File: doc/BRIEF.md
# Programmable Channel Clock Divider Bank

This block divides an input clock for a set of output channels. Each channel has its own high-phase count and low-phase count, so its output stays high for one more input cycle than the high count and low for one more input cycle than the low count. The division ratio is the sum of the two counts plus two. A channel can also pass the input clock straight through, or stretch the high phase of an odd ratio by half an input cycle to reach a 50% duty cycle.

Each channel has a coarse start delay, counted in whole input cycles. It is built from a 4-bit offset and a start-high flag. Configuration is presented on plain input ports and is captured only while the shared sync input is asserted. While sync is held, every output is low. The first rising input edge after sync is released starts all channels together, so the relative delays between them are exactly the programmed values. A synchronous active-low reset clears the captured settings and keeps all outputs low until the first sync.

Top module: `chdiv_bank`

## Requirements
- R1: Once a channel is running, its output repeats with a period of hi+lo+2 input cycles, where hi and lo are that channel's 4-bit counts.
- R2: With no stretch in effect, each output period has hi+1 input cycles high followed by lo+1 cycles low, and the high level starts on a rising input edge.
- R3: With the start-high flag at 0, the first rising output edge occurs on the rising input edge that is po cycles after the first edge at which sync is sampled low. Here po is the 4-bit offset, and an offset of 0 rises on that first edge.
- R4: With the start-high flag at 1, the first rising output edge is delayed by po+lo+1 input cycles instead of po.
- R5: A change of any configuration input while sync is low has no effect on any output.
- R6: When the captured bypass bit of a channel is 1, its output equals the input clock level.
- R7: When the captured stretch bit is 1 and lo equals hi+1, each high phase ends on the falling input edge half a cycle after its normal end, giving hi+1.5 cycles high and hi+1.5 cycles low. For any other pair of counts the stretch bit has no effect.
- R8: With the stretch bit set and lo equal to hi, the output is the same as without stretch, which is already 50% duty.
- R9: While sync is sampled high, every divided output is low. All channels then restart together at the first edge with sync low, so their delays are measured from that shared edge.
- R10: After reset, and until the first sync, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | Holds outputs low and captures configuration while high |
| cfg_hi | input | NCH*CW | Per-channel high count, channel c at bits [c*CW +: CW] |
| cfg_lo | input | NCH*CW | Per-channel low count |
| cfg_po | input | NCH*CW | Per-channel coarse delay offset |
| cfg_sh | input | NCH | Per-channel start-high flag |
| cfg_byp | input | NCH | Per-channel bypass select |
| cfg_dcc | input | NCH | Per-channel odd-ratio duty stretch enable |
| clk_out | output | NCH | Divided clock per channel |

## Verification
The bench builds the block with three channels and a 4-bit count width, which are the defaults. This allows ratios from 2 up to 32 and start delays from 0 up to 31 cycles, with the largest delay reached through the start-high formula when both counts are 15. Three channels are enough to release different offsets from one sync at the same moment and to compare their relative alignment. They also let bypass, stretch and plain division run side by side. The output is compared in both halves of every input cycle, so both the half-cycle stretch and the bypass level are observed directly.

// File: rtl/chdiv_pkg.sv
`timescale 1ns/1ps
// Shared types for the channel divider bank.
// Assumes: nothing beyond standard SystemVerilog.
package chdiv_pkg;
    // Phases of one channel's countdown sequencer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } div_state_e;
endpackage

// File: rtl/chdiv_shadow.sv
`timescale 1ns/1ps
// Captures one channel's configuration while load is high and keeps it
// steady otherwise. It also derives the start delay from the incoming
// values, so a single-cycle load is enough.
// Assumes: load is synchronous to clk.
module chdiv_shadow #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] in_hi,
    input  logic [CW-1:0] in_lo,
    input  logic [CW-1:0] in_po,
    input  logic          in_sh,
    input  logic          in_byp,
    input  logic          in_dcc,
    output logic [CW-1:0] hi,
    output logic [CW-1:0] lo,
    output logic          byp,
    output logic          dcc_act,
    output logic [CW:0]   ld_delay,
    output logic [3*CW+2:0] bus
);
    localparam int DW = CW + 1;

    logic [CW-1:0] po_q;
    logic          sh_q;
    logic          dcc_q;

    // Hold the settings; take new ones only while load is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi    <= '0;
            lo    <= '0;
            po_q  <= '0;
            sh_q  <= 1'b0;
            byp   <= 1'b0;
            dcc_q <= 1'b0;
        end else if (load) begin
            hi    <= in_hi;
            lo    <= in_lo;
            po_q  <= in_po;
            sh_q  <= in_sh;
            byp   <= in_byp;
            dcc_q <= in_dcc;
        end
    end

    // Start delay from the values being loaded: offset, plus low count + 1 when start-high.
    always_comb begin
        if (in_sh) ld_delay = {1'b0, in_po} + {1'b0, in_lo} + DW'(1);
        else       ld_delay = {1'b0, in_po};
    end

    // The stretch only applies to the odd ratio where lo = hi + 1.
    assign dcc_act = dcc_q && ({1'b0, lo} == ({1'b0, hi} + DW'(1)));

    // Flat view of the captured state for the checker.
    assign bus = {hi, lo, po_q, sh_q, byp, dcc_q};
endmodule

// File: rtl/chdiv_core.sv
`timescale 1ns/1ps
// Countdown sequencer for one channel. On sync it loads the start delay
// and holds its output low. After release it counts the delay down and
// then alternates hi+1 high cycles with lo+1 low cycles.
// Assumes: hi and lo are stable whenever sync is low.
module chdiv_core
    import chdiv_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    input  logic [CW:0]   ld_delay,
    output logic          q
);
    localparam int DW = CW + 1;

    div_state_e    st;
    logic [DW-1:0] cnt;

    // Sequencer: delay countdown first, then high/low alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            q   <= 1'b0;
        end else if (sync) begin
            st  <= ST_DELAY;
            cnt <= ld_delay;
            q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    q <= 1'b0;
                end
                ST_DELAY, ST_LOW: begin
                    if (cnt == '0) begin
                        q   <= 1'b1;
                        st  <= ST_HIGH;
                        cnt <= {1'b0, hi};
                    end else begin
                        cnt <= cnt - DW'(1);
                    end
                end
                ST_HIGH: begin
                    if (cnt == '0) begin
                        q   <= 1'b0;
                        st  <= ST_LOW;
                        cnt <= {1'b0, lo};
                    end else begin
                        cnt <= cnt - DW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chdiv_outstage.sv
`timescale 1ns/1ps
// Output stage for one channel. It selects the raw input clock in bypass.
// Otherwise it drives the divided level, whose high phase can be extended
// by half a cycle through a falling-edge copy of it.
// Assumes: q changes only on rising clk edges.
module chdiv_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic q,
    input  logic byp,
    input  logic dcc_act,
    output logic clk_o
);
    logic q_neg;

    // Falling-edge copy of the divided level; it holds the end of high half a cycle longer.
    always_ff @(negedge clk) begin
        if (!rst_n) q_neg <= 1'b0;
        else        q_neg <= q;
    end

    // Select bypass clock or the divided level (optionally stretched).
    assign clk_o = byp ? clk : (q | (dcc_act & q_neg));
endmodule

// File: rtl/chdiv_bank.sv
`timescale 1ns/1ps
// Bank of NCH programmable clock dividers that share one sync input.
// Every channel captures its settings and restarts on the same edge, so
// the programmed delays between channels are kept.
// Assumes: sync_req and the cfg_* ports are synchronous to clk_in.
module chdiv_bank #(
    parameter int NCH = 3,
    parameter int CW  = 4
) (
    input  logic            clk_in,
    input  logic            rst_n,
    input  logic            sync_req,
    input  logic [NCH*CW-1:0] cfg_hi,
    input  logic [NCH*CW-1:0] cfg_lo,
    input  logic [NCH*CW-1:0] cfg_po,
    input  logic [NCH-1:0]  cfg_sh,
    input  logic [NCH-1:0]  cfg_byp,
    input  logic [NCH-1:0]  cfg_dcc,
    output logic [NCH-1:0]  clk_out
);
    localparam int SBW = 3 * CW + 3;

    logic [NCH-1:0]     core_q;
    logic [NCH*SBW-1:0] shadow_bus;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CW-1:0] hi, lo;
        logic          byp, dcc_act;
        logic [CW:0]   ld_delay;

        chdiv_shadow #(.CW(CW)) u_shadow (
            .clk      (clk_in),
            .rst_n    (rst_n),
            .load     (sync_req),
            .in_hi    (cfg_hi[c*CW +: CW]),
            .in_lo    (cfg_lo[c*CW +: CW]),
            .in_po    (cfg_po[c*CW +: CW]),
            .in_sh    (cfg_sh[c]),
            .in_byp   (cfg_byp[c]),
            .in_dcc   (cfg_dcc[c]),
            .hi       (hi),
            .lo       (lo),
            .byp      (byp),
            .dcc_act  (dcc_act),
            .ld_delay (ld_delay),
            .bus      (shadow_bus[c*SBW +: SBW])
        );

        chdiv_core #(.CW(CW)) u_core (
            .clk      (clk_in),
            .rst_n    (rst_n),
            .sync     (sync_req),
            .hi       (hi),
            .lo       (lo),
            .ld_delay (ld_delay),
            .q        (core_q[c])
        );

        chdiv_outstage u_out (
            .clk     (clk_in),
            .rst_n   (rst_n),
            .q       (core_q[c]),
            .byp     (byp),
            .dcc_act (dcc_act),
            .clk_o   (clk_out[c])
        );
    end
endmodule

// File: rtl/chdiv_bank_chk.sv
`timescale 1ns/1ps
// Property checker for chdiv_bank, attached through bind below.
// Assumes: it sees the bank's divided levels and captured settings.
module chdiv_bank_chk #(
    parameter int NCH = 3,
    parameter int CW  = 4
) (
    input logic                       clk_in,
    input logic                       rst_n,
    input logic                       sync_req,
    input logic [NCH-1:0]             core_q,
    input logic [NCH*(3*CW+3)-1:0]    shadow_bus
);
    localparam int HMAX = 2 ** CW;

    logic seen_sync;

    // Remember whether any sync has been sampled since reset.
    always_ff @(posedge clk_in) begin
        if (!rst_n)        seen_sync <= 1'b0;
        else if (sync_req) seen_sync <= 1'b1;
    end

    // R10: every divided level stays low before the first sync.
    assert_low_before_sync_R10: assert property (@(posedge clk_in) disable iff (!rst_n)
        !seen_sync |-> core_q == '0);

    // R9: the cycle after sync is sampled high, all levels are low.
    assert_sync_holds_low_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
        sync_req |=> core_q == '0);

    // R5: the captured settings do not move without sync.
    assert_cfg_frozen_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        !sync_req |=> $stable(shadow_bus));

    for (genvar c = 0; c < NCH; c++) begin : g_run
        int unsigned run;

        // Count consecutive high cycles of this channel.
        always_ff @(posedge clk_in) begin
            if (!rst_n || sync_req) run <= 0;
            else if (core_q[c])     run <= run + 1;
            else                    run <= 0;
        end

        // R2: a high phase never exceeds hi+1 <= 2**CW cycles.
        assert_high_run_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
            run <= HMAX);
    end
endmodule

bind chdiv_bank chdiv_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .sync_req   (sync_req),
    .core_q     (core_q),
    .shadow_bus (shadow_bus)
);

// File: tb/tb_chdiv_bank.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural position-based model is compared with
// every output in both halves of every input cycle.
module tb_chdiv_bank;
    localparam int NCH = 3;
    localparam int CW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic [NCH*CW-1:0] cfg_hi = '0, cfg_lo = '0, cfg_po = '0;
    logic [NCH-1:0] cfg_sh = '0, cfg_byp = '0, cfg_dcc = '0;
    logic [NCH-1:0] clk_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string cur_req = "R10";

    // Model state per channel.
    int  k[NCH];
    bit  armed[NCH];
    bit  qprev[NCH];
    int  sN[NCH], sM[NCH], sD[NCH];
    bit  sB[NCH], sC[NCH];

    always #4 clk = ~clk;   // 125 MHz

    chdiv_bank #(.NCH(NCH), .CW(CW)) dut (
        .clk_in(clk), .rst_n(rst_n), .sync_req(sync_req),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_po(cfg_po),
        .cfg_sh(cfg_sh), .cfg_byp(cfg_byp), .cfg_dcc(cfg_dcc),
        .clk_out(clk_out)
    );

    // Divided level from the position since release.
    function automatic bit mq(int c);
        if (!armed[c] || k[c] < sD[c]) return 1'b0;
        return ((k[c] - sD[c]) % (sN[c] + sM[c] + 2)) <= sN[c];
    endfunction

    // Advance the model at a rising edge, using the inputs being sampled.
    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            qprev[c] = mq(c);
            if (!rst_n) begin
                armed[c] = 0; k[c] = 0;
                sN[c] = 0; sM[c] = 0; sD[c] = 0; sB[c] = 0; sC[c] = 0;
            end else if (sync_req) begin
                sN[c] = int'(cfg_hi[c*CW +: CW]);
                sM[c] = int'(cfg_lo[c*CW +: CW]);
                sD[c] = cfg_sh[c] ? int'(cfg_po[c*CW +: CW]) + sM[c] + 1
                                  : int'(cfg_po[c*CW +: CW]);
                sB[c] = cfg_byp[c];
                sC[c] = cfg_dcc[c];
                armed[c] = 1; k[c] = -1;
            end else if (armed[c]) begin
                k[c]++;
            end
        end
    endtask

    task automatic compare(bit high_half);
        for (int c = 0; c < NCH; c++) begin
            bit exp;
            bit stretch = sC[c] && (sM[c] == sN[c] + 1);
            if (sB[c])          exp = high_half;
            else if (high_half) exp = mq(c) | (stretch & qprev[c]);
            else                exp = mq(c);
            vectors++;
            if (clk_out[c] !== exp) begin
                errors++;
                $display("FAIL %s ch%0d %s half @%0t: out=%b expected %b",
                         cur_req, c, high_half ? "high" : "low", $time, clk_out[c], exp);
            end
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); model_edge(); #2; compare(1);
            @(negedge clk); #2; compare(0);
        end
    endtask

    task automatic set_ch(int c, int n, int m, int po, bit sh, bit byp, bit dcc);
        cfg_hi[c*CW +: CW] = CW'(n);
        cfg_lo[c*CW +: CW] = CW'(m);
        cfg_po[c*CW +: CW] = CW'(po);
        cfg_sh[c] = sh; cfg_byp[c] = byp; cfg_dcc[c] = dcc;
    endtask

    task automatic pulse_sync(int len);
        sync_req = 1'b1; cyc(len);
        sync_req = 1'b0;
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: out=timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset, then outputs stay low before any sync even with config present.
        cur_req = "R10";
        cyc(3);
        rst_n = 1'b1;
        set_ch(0, 1, 1, 0, 0, 0, 0);
        cyc(10);

        // R1/R2/R3/R9: plain division, different offsets, released together.
        cur_req = "R1/R2/R3/R9";
        set_ch(0, 1, 1, 0, 0, 0, 0);
        set_ch(1, 2, 5, 3, 0, 0, 0);
        set_ch(2, 0, 0, 7, 0, 0, 0);
        pulse_sync(1);
        cyc(80);

        // R5: change every setting without sync; outputs keep running unchanged.
        cur_req = "R5";
        set_ch(0, 9, 2, 11, 1, 1, 1);
        set_ch(1, 0, 0, 0, 1, 1, 0);
        set_ch(2, 4, 5, 2, 0, 0, 1);
        cyc(40);

        // R4/R3: start-high delays, including the longest delay and ratio 32.
        cur_req = "R4/R3";
        set_ch(0, 3, 4, 2, 1, 0, 0);
        set_ch(1, 15, 15, 15, 1, 0, 0);
        set_ch(2, 2, 2, 15, 0, 0, 0);
        pulse_sync(1);
        cyc(110);

        // R7/R8: stretch on an odd ratio, no change on even or other ratios.
        cur_req = "R7/R8";
        set_ch(0, 2, 3, 0, 0, 0, 1);
        set_ch(1, 3, 3, 1, 0, 0, 1);
        set_ch(2, 2, 4, 0, 0, 0, 1);
        pulse_sync(1);
        cyc(50);
        set_ch(0, 0, 1, 3, 0, 0, 1);
        pulse_sync(1);
        cyc(30);

        // R6: bypass on one channel while the others keep dividing.
        cur_req = "R6";
        set_ch(1, 5, 5, 0, 0, 1, 0);
        pulse_sync(1);
        cyc(20);

        // R9: long sync hold keeps everything low, then a common restart.
        cur_req = "R9";
        set_ch(1, 1, 2, 4, 0, 0, 0);
        pulse_sync(6);
        cyc(40);

        // R10: reset mid-run returns outputs to low until the next sync.
        cur_req = "R10";
        rst_n = 1'b0; cyc(2);
        rst_n = 1'b1; cyc(10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule